// File: doc/BRIEF.md
# Host-Readable Transfer Register Controller

This block keeps the bytes that a host reads over a register bus after a data line or a data packet has been decoded from the video signal. Two acquisition paths share it: a line-coded path and a packet path. In the packet path some packets carry error-checked control data and others carry plain time-of-day bytes. Each path raises a store request with a full set of bytes. The block accepts the request only when no host read is under way, and it fills every byte with all ones once a read has finished.

The block also drives two status pins. The first is an active-low data-valid flag. An accepted store of checked data pulls it low. A master NACK on the bus releases it, and so does a field or line event chosen by the operating mode. The second is an active-high first-field flag that follows the field parity. A test input switches both pins to copy a chip-select input. The bus protocol engine sits outside the block and supplies a read-active level, start and advance pulses, and a NACK pulse.

Top module: `xfer_reg_ctrl`

## Requirements
- R1: After reset, `davn_o` is 1, `ehb_o` is 0 and every byte reads 8'hFF.
- R2: A store request (`st_valid`=1) in a cycle where `rd_active`=0 loads all bytes from `st_data`. Byte i is `st_data[8*i+7:8*i]`, and it can be read from the next cycle on.
- R3: A store request in a cycle where `rd_active`=1 is dropped and not queued. Neither the bytes nor `davn_o` change.
- R4: In the cycle after `rd_active` falls, every byte reads 8'hFF. If a store is accepted in the cycle where `rd_active` falls, the stored data wins.
- R5: `rd_data` shows the byte at the read address. `rd_start` sets the address to 0 and `rd_adv` (while `rd_active`=1) adds 1. After the last byte (NUM_BYTES-1) the address wraps to 0.
- R6: An accepted store with `st_kind`=0 (checked data) drives `davn_o` low in the next cycle. With `st_kind`=1 (time-of-day bytes) it leaves `davn_o` unchanged.
- R7: `rd_nack`=1 while `rd_active`=1 sets `davn_o` high in the next cycle.
- R8: With `mode_pkt`=1 (packet mode), `field_start` sets `davn_o` high and `line16_start` has no effect. With `mode_pkt`=0 (line mode) the two swap roles. A low-setting store in the same cycle takes priority.
- R9: `field_start` with `field_odd`=1 sets `ehb_o` high in the next cycle, and with `field_odd`=0 sets it low.
- R10: While `test_en`=1, `davn_o` and `ehb_o` both equal `test_cs` in the same cycle. The internal flags keep updating and show again once `test_en` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pkt | input | 1 | 1 = packet mode, 0 = line mode |
| st_valid | input | 1 | Store request from acquisition |
| st_kind | input | 1 | 0 = checked data, 1 = time-of-day bytes |
| st_data | input | NUM_BYTES*8 | Bytes to store, byte 0 in the low bits |
| field_start | input | 1 | Pulse at the start of a field / data entry window |
| field_odd | input | 1 | Parity of the starting field, 1 = first field |
| line16_start | input | 1 | Pulse at the start of the data line |
| rd_active | input | 1 | Host read transaction in progress |
| rd_start | input | 1 | Pulse at the start of a read transaction |
| rd_adv | input | 1 | Advance the read address by one byte |
| rd_nack | input | 1 | Master did not acknowledge |
| rd_data | output | 8 | Byte at the current read address |
| test_en | input | 1 | Test override enable |
| test_cs | input | 1 | Level copied to both flags in test mode |
| davn_o | output | 1 | Data valid, active low |
| ehb_o | output | 1 | First field, active high |

## Verification
A fault in the accept gate shows on the bus in the very next read. A blocked store that still lands changes `rd_data` during the same transaction, and a lost refill leaves stale bytes in the first read after the transaction ends. A flag that takes the wrong release event, for example line 16 in packet mode, shows on `davn_o` one cycle after that event. The bench sets up each case with the other events held idle, so the cause can be pinned down. A wrong read-address wrap shows only on the byte after the last one, so the bench walks a full round.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   localparam byte_t FILL_BYTE = '1;
   typedef enum logic {
      KIND_CODED = 1'b0,
      KIND_TIME  = 1'b1
   } st_kind_e;
endpackage

// File: rtl/xfer_store_bank.sv
module xfer_store_bank
   import xfer_pkg::*;
#(
   parameter int NUM_BYTES = 13,
   localparam int ADDR_W = $clog2(NUM_BYTES),
   localparam int FLAT_W = NUM_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAT_W-1:0] load_data,
   input  logic              refill,
   input  logic [ADDR_W-1:0] rd_addr,
   output byte_t             rd_byte
);
   logic [FLAT_W-1:0] bank_q;
   byte_t             bytes_v [NUM_BYTES];

   // A load wins over the refill when both land in one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '1;
      end else if (load) begin
         bank_q <= load_data;
      end else if (refill) begin
         for (int i = 0; i < NUM_BYTES; i++) begin
            bank_q[i*BYTE_W +: BYTE_W] <= FILL_BYTE;
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
         assign bytes_v[g] = bank_q[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign rd_byte = bytes_v[rd_addr];
endmodule

// File: rtl/xfer_rd_ptr.sv
module xfer_rd_ptr #(
   parameter int NUM_BYTES = 13,
   localparam int ADDR_W = $clog2(NUM_BYTES),
   localparam bit POW2 = ((1 << ADDR_W) == NUM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BYTES - 1);
   logic [ADDR_W-1:0] nxt;

   generate
      if (POW2) begin : g_natural
         assign nxt = addr + 1'b1;
      end else begin : g_cmp
         assign nxt = (addr == LAST) ? '0 : addr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (start) addr <= '0;
      else if (adv)   addr <= nxt;
   end
endmodule

// File: rtl/xfer_status.sv
module xfer_status (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_pkt,
   input  logic set_low,
   input  logic nack_rel,
   input  logic field_start,
   input  logic field_odd,
   input  logic line16_start,
   input  logic test_en,
   input  logic test_cs,
   output logic davn_st,
   output logic ehb_st,
   output logic davn_o,
   output logic ehb_o
);
   logic mode_rel;

   assign mode_rel = mode_pkt ? field_start : line16_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         davn_st <= 1'b1;
         ehb_st  <= 1'b0;
      end else begin
         if (set_low)                   davn_st <= 1'b0;
         else if (nack_rel || mode_rel) davn_st <= 1'b1;
         if (field_start)               ehb_st  <= field_odd;
      end
   end

   assign davn_o = test_en ? test_cs : davn_st;
   assign ehb_o  = test_en ? test_cs : ehb_st;
endmodule

// File: rtl/xfer_reg_ctrl.sv
module xfer_reg_ctrl
   import xfer_pkg::*;
#(
   parameter int NUM_BYTES = 13,
   localparam int ADDR_W = $clog2(NUM_BYTES),
   localparam int FLAT_W = NUM_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_pkt,
   input  logic              st_valid,
   input  logic              st_kind,
   input  logic [FLAT_W-1:0] st_data,
   input  logic              field_start,
   input  logic              field_odd,
   input  logic              line16_start,
   input  logic              rd_active,
   input  logic              rd_start,
   input  logic              rd_adv,
   input  logic              rd_nack,
   output logic [7:0]        rd_data,
   input  logic              test_en,
   input  logic              test_cs,
   output logic              davn_o,
   output logic              ehb_o
);
   generate
      if (NUM_BYTES < 2 || NUM_BYTES > 256) begin : g_bad_depth
         $error("xfer_reg_ctrl: NUM_BYTES must lie in 2..256");
      end
   endgenerate

   logic              store_ok;
   logic              set_low;
   logic              rd_q;
   logic              rd_end;
   logic [ADDR_W-1:0] rd_addr;
   logic              davn_st;
   logic              ehb_st;

   assign store_ok = st_valid && !rd_active;
   assign set_low  = store_ok && (st_kind_e'(st_kind) == KIND_CODED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_active;
   end
   assign rd_end = rd_q && !rd_active;

   xfer_store_bank #(.NUM_BYTES(NUM_BYTES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (store_ok),
      .load_data (st_data),
      .refill    (rd_end),
      .rd_addr   (rd_addr),
      .rd_byte   (rd_data)
   );

   xfer_rd_ptr #(.NUM_BYTES(NUM_BYTES)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rd_start),
      .adv   (rd_adv && rd_active),
      .addr  (rd_addr)
   );

   xfer_status u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_pkt     (mode_pkt),
      .set_low      (set_low),
      .nack_rel     (rd_nack && rd_active),
      .field_start  (field_start),
      .field_odd    (field_odd),
      .line16_start (line16_start),
      .test_en      (test_en),
      .test_cs      (test_cs),
      .davn_st      (davn_st),
      .ehb_st       (ehb_st),
      .davn_o       (davn_o),
      .ehb_o        (ehb_o)
   );
endmodule

// File: rtl/xfer_reg_ctrl_chk.sv
module xfer_reg_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_pkt,
   input logic       st_valid,
   input logic       st_kind,
   input logic       line16_start,
   input logic       field_start,
   input logic       field_odd,
   input logic       rd_active,
   input logic       rd_nack,
   input logic [7:0] rd_data,
   input logic       test_en,
   input logic       test_cs,
   input logic       davn_st,
   input logic       ehb_st,
   input logic       davn_o,
   input logic       ehb_o
);
   logic rd_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev <= 1'b0;
      else        rd_prev <= rd_active;
   end

   // R6
   p_store_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !rd_active && !st_kind) |=> !davn_st);

   // R7
   p_nack_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_active && rd_nack) |=> davn_st);

   // R3
   p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_active |=> !$fell(davn_st));

   // R4
   p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_prev && !rd_active && !st_valid) |=> (rd_data == 8'hFF));

   // R8
   p_line_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pkt && line16_start && !(st_valid && !rd_active && !st_kind)) |=> davn_st);

   // R9
   p_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> (ehb_st == $past(field_odd)));

   // R10
   p_test_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |-> (davn_o == test_cs && ehb_o == test_cs));
endmodule

bind xfer_reg_ctrl xfer_reg_ctrl_chk u_chk (.*);

// File: tb/xfer_reg_ctrl_tb.sv
module xfer_reg_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 13;
   localparam int FW = NB * 8;

   // Row fields: [9]mode [8]st_valid [7]kind [6]rd_active [5]nack
   // [4]field_start [3]field_odd [2]line16 [1]exp davn [0]exp ehb
   localparam logic [9:0] TBL [15] = '{
      10'b1000011011, // R9 first field
      10'b1100000001, // R6 checked store
      10'b1000000101, // R8 line event ignored in packet mode
      10'b1000010010, // R8 R9 field release, second field
      10'b1110000010, // R6 time packet keeps flag
      10'b1100000000, // R6
      10'b1101000000, // R3 blocked
      10'b1001100010, // R7 nack
      10'b1101000010, // R3 blocked store cannot lower
      10'b0100000000, // R4 store wins at read end
      10'b0000011001, // R8 field ignored in line mode, R9
      10'b0000000111, // R8 line release
      10'b0100000101, // R8 store beats release
      10'b1100010000, // R8 store beats field release
      10'b1000000000
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic mode_pkt = 1'b1, st_valid = 1'b0, st_kind = 1'b0;
   logic [FW-1:0] st_data = '0;
   logic field_start = 1'b0, field_odd = 1'b0, line16_start = 1'b0;
   logic rd_active = 1'b0, rd_start = 1'b0, rd_adv = 1'b0, rd_nack = 1'b0;
   logic test_en = 1'b0, test_cs = 1'b0;
   logic [7:0] rd_data;
   logic davn_o, ehb_o;

   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_reg_ctrl #(.NUM_BYTES(NB)) u_dut (.*);

   function automatic logic [FW-1:0] pat(input logic [7:0] seed);
      for (int i = 0; i < NB; i++) pat[i*8 +: 8] = seed + 8'(i * 29);
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      logic [FW-1:0] pa, pb;
      pa = pat(8'h10);
      pb = pat(8'h03);
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 davn", 8'(davn_o), 8'd1);
      chk("R1 ehb", 8'(ehb_o), 8'd0);
      chk("R1 byte", rd_data, 8'hFF);
      rst_n = 1'b1;
      step();

      st_data = pa;
      for (int r = 0; r < 15; r++) begin
         {mode_pkt, st_valid, st_kind, rd_active, rd_nack,
          field_start, field_odd, line16_start} = TBL[r][9:2];
         step();
         chk($sformatf("R3/R6/R7/R8/R9 row %0d davn", r), 8'(davn_o), 8'(TBL[r][1]));
         chk($sformatf("R9 row %0d ehb", r), 8'(ehb_o), 8'(TBL[r][0]));
      end
      {st_valid, st_kind, rd_active, rd_nack, field_start, field_odd, line16_start} = '0;
      mode_pkt = 1'b1;
      step();

      // R2 R6: time-packet store loads data and keeps davn low
      st_data = pb; st_kind = 1'b1; st_valid = 1'b1;
      step();
      st_valid = 1'b0; st_kind = 1'b0;
      chk("R6 time store davn", 8'(davn_o), 8'd0);
      // R5 full walk with wrap
      rd_active = 1'b1; rd_start = 1'b1;
      step();
      rd_start = 1'b0;
      chk("R2 byte 0", rd_data, pb[7:0]);
      for (int i = 1; i <= NB; i++) begin
         rd_adv = 1'b1;
         step();
         chk($sformatf("R2/R5 byte %0d", i % NB), rd_data, pb[(i % NB)*8 +: 8]);
      end
      rd_adv = 1'b0;
      // R7 nack
      rd_nack = 1'b1;
      step();
      rd_nack = 1'b0;
      chk("R7 nack davn", 8'(davn_o), 8'd1);
      // R3 blocked store
      st_data = pa; st_valid = 1'b1;
      step();
      st_valid = 1'b0;
      chk("R3 data kept", rd_data, pb[7:0]);
      chk("R3 davn kept", 8'(davn_o), 8'd1);
      // R4 refill after read end
      rd_active = 1'b0;
      step();
      rd_active = 1'b1; rd_start = 1'b1;
      step();
      rd_start = 1'b0;
      for (int i = 0; i < NB; i++) begin
         chk($sformatf("R4 byte %0d", i), rd_data, 8'hFF);
         rd_adv = 1'b1;
         step();
      end
      rd_adv = 1'b0; rd_active = 1'b0;
      step();

      // R10 test override
      test_en = 1'b1; test_cs = 1'b0;
      #1;
      chk("R10 davn cs0", 8'(davn_o), 8'd0);
      chk("R10 ehb cs0", 8'(ehb_o), 8'd0);
      test_cs = 1'b1;
      #1;
      chk("R10 davn cs1", 8'(davn_o), 8'd1);
      chk("R10 ehb cs1", 8'(ehb_o), 8'd1);
      test_cs = 1'b0;
      field_start = 1'b1; field_odd = 1'b1;
      step();
      field_start = 1'b0; field_odd = 1'b0;
      chk("R10 held under test", 8'(ehb_o), 8'd0);
      test_en = 1'b0;
      #1;
      chk("R10 internal ehb", 8'(ehb_o), 8'd1);
      chk("R10 internal davn", 8'(davn_o), 8'd1);

      // R1 reset mid-run
      st_data = pa; st_valid = 1'b1;
      step();
      st_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R1 reset davn", 8'(davn_o), 8'd1);
      chk("R1 reset ehb", 8'(ehb_o), 8'd0);
      chk("R1 reset byte", rd_data, 8'hFF);
      step();
      rst_n = 1'b1;
      step();

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule